// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

A single-port static memory whose inputs and output are both registered. On every rising clock edge the block captures an 18-bit word address, three active-low controls (chip select, write strobe, output strobe) and a 9-bit write word. From those controls it decides whether the cycle is a read, a write, a plain idle or a sleep. A read places the addressed word into an output register one clock after the request was captured, so a stream of reads produces one word per cycle. A write stores the word captured alongside its address.

The shared three-state data pin is split into `wr_data`, `rd_data` and `rd_drive`, so the block stays synthesizable; a pad wrapper can merge them. The array depth is a parameter. Address bits above the array size fold onto the array modulo `DEPTH`, which lets a simulation build use a small array behind the full 18-bit address. A `sleeping` flag reports cycles that were deselected by the chip select.

Top module: `pipe_sram`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `rd_drive` is 0, `sleeping` is 0 and `rd_data` is 0, whatever the control inputs do.
- R2: An edge that captures `cs_n`=0, `we_n`=1 and `oe_n`=0 is a read. After the next rising edge, `rd_data` carries the word at the captured address and `rd_drive` is 1, for one cycle.
- R3: An edge that captures `cs_n`=0 and `we_n`=0 is a write, whatever `oe_n` is. It stores the `wr_data` captured at that same edge at the captured address.
- R4: An edge that captures `cs_n`=1 writes nothing and reads nothing. `rd_drive` is 0 after the next rising edge.
- R5: An edge that captures `cs_n`=0, `we_n`=1 and `oe_n`=1 writes nothing and reads nothing. `sleeping` stays 0 in the following cycle, and `rd_drive` is 0 after the next rising edge.
- R6: `sleeping` is 1 in exactly those cycles that follow an edge which captured `cs_n`=1 outside reset.
- R7: After a write, `rd_drive` is 0 in the cycle in which a read issued at the same edge would have driven data.
- R8: A read issued at the edge right after a write to the same address returns the newly written word.
- R9: Reads issued at consecutive edges return their words on consecutive cycles, each word one cycle after its own request.
- R10: While `rd_drive` is 0, `rd_data` keeps the value of the last completed read, or 0 if there has been no read since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 18 | Word address, captured at each edge |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| wr_data | input | 9 | Write word, captured with the address |
| rd_data | output | 9 | Output register contents |
| rd_drive | output | 1 | High when the output register should drive the bus |
| sleeping | output | 1 | High for the cycle after a chip-select deselect |

## Verification
The hardest case to reach from the ports is the one where a read immediately follows a write to the same word. The write lands in the array one edge after its capture, which is the same edge at which the trailing read is captured. The stimulus table places that pair back to back. It also puts writes that are suppressed by both deselect forms in front of later reads of the same address, so a stray write would show up as wrong read data. The output hold is checked on every cycle where the drive is low, against the last word the bench expects to have been read.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SLEEP = 2'd3
    } op_e;

    function automatic op_e classify(input logic cs_n, input logic we_n, input logic oe_n);
        if (cs_n)
            return OP_SLEEP;
        else if (!we_n)
            return OP_WRITE;
        else if (!oe_n)
            return OP_READ;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/pipe_sram_capture.sv
module pipe_sram_capture
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wr_data,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            op_q   <= classify(cs_n, we_n, oe_n);
            addr_q <= addr;
            data_q <= wr_data;
        end
    end

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [DATA_W-1:0] cells [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx   = IDX_W'(addr % DEPTH_A);
    assign rdata = cells[idx];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[idx] <= wdata;
    end

endmodule

// File: rtl/pipe_sram_drive.sv
module pipe_sram_drive
    import pipe_sram_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_q,
    input  logic [DATA_W-1:0] array_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_drive <= 1'b0;
        end else begin
            rd_drive <= (op_q == OP_READ);
            if (op_q == OP_READ)
                rd_data <= array_word;
        end
    end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              sleeping
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] array_word;

    pipe_sram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .wr_data (wr_data),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .data_q  (data_q)
    );

    pipe_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .wr_en (op_q == OP_WRITE),
        .addr  (addr_q),
        .wdata (data_q),
        .rdata (array_word)
    );

    pipe_sram_drive #(.DATA_W(DATA_W)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .op_q       (op_q),
        .array_word (array_word),
        .rd_data    (rd_data),
        .rd_drive   (rd_drive)
    );

    assign sleeping = (op_q == OP_SLEEP);

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive,
    input logic              sleeping
);

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && !oe_n) |=> ##1 rd_drive);

    assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ##1 !rd_drive);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && oe_n) |=> (!sleeping ##1 !rd_drive));

    assert_sleep_set_R6: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> sleeping);

    assert_sleep_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> !sleeping);

    assert_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> ##1 !rd_drive);

    assert_hold_output_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_drive && !$past(rst)) |-> $stable(rd_data));

    logic unused_ok;
    assign unused_ok = ^{addr, wr_data};

endmodule

bind pipe_sram pipe_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_drive (rd_drive),
    .sleeping (sleeping)
);

// File: tb/pipe_sram_test.sv
module pipe_sram_test;

    localparam int AW = 18;
    localparam int DW = 9;

    typedef struct packed {
        logic          cs_n;
        logic          we_n;
        logic          oe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        logic          e_drive;
        logic [DW-1:0] e_data;
        logic          e_sleep;
    } vec_t;

    localparam int NV = 16;
    // e_drive/e_data: seen two negedges after the row is applied; e_sleep: one.
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 1'b0, 1'b1, 18'd5, 9'h1A5, 1'b0, 9'h000, 1'b0}, // R3 write, oe_n high
        '{1'b0, 1'b0, 1'b0, 18'd6, 9'h0F3, 1'b0, 9'h000, 1'b0}, // R3 write, oe_n low, R7
        '{1'b0, 1'b1, 1'b0, 18'd5, 9'h000, 1'b1, 9'h1A5, 1'b0}, // R2 read
        '{1'b0, 1'b0, 1'b1, 18'd7, 9'h155, 1'b0, 9'h1A5, 1'b0}, // write, R10 hold
        '{1'b0, 1'b1, 1'b0, 18'd7, 9'h000, 1'b1, 9'h155, 1'b0}, // R8 read right after write
        '{1'b0, 1'b1, 1'b0, 18'd6, 9'h000, 1'b1, 9'h0F3, 1'b0}, // R9 stream
        '{1'b0, 1'b1, 1'b0, 18'd7, 9'h000, 1'b1, 9'h155, 1'b0}, // R9 stream
        '{1'b1, 1'b0, 1'b0, 18'd5, 9'h000, 1'b0, 9'h155, 1'b1}, // R4 cs_n high blocks write, R6
        '{1'b0, 1'b1, 1'b1, 18'd6, 9'h000, 1'b0, 9'h155, 1'b0}, // R5 idle, R10
        '{1'b0, 1'b1, 1'b0, 18'd5, 9'h000, 1'b1, 9'h1A5, 1'b0}, // R4 word 5 unchanged
        '{1'b0, 1'b0, 1'b0, 18'd8, 9'h1FF, 1'b0, 9'h1A5, 1'b0}, // write
        '{1'b1, 1'b1, 1'b0, 18'd8, 9'h000, 1'b0, 9'h1A5, 1'b1}, // R6 sleep
        '{1'b1, 1'b1, 1'b1, 18'd8, 9'h000, 1'b0, 9'h1A5, 1'b1}, // R6 sleep
        '{1'b0, 1'b1, 1'b0, 18'd8, 9'h000, 1'b1, 9'h1FF, 1'b0}, // R2 read after sleep
        '{1'b0, 1'b1, 1'b1, 18'd8, 9'h000, 1'b0, 9'h1FF, 1'b0}, // R5 idle
        '{1'b0, 1'b1, 1'b1, 18'd0, 9'h000, 1'b0, 9'h1FF, 1'b0}  // R10 hold
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b0;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;
    logic          sleeping;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pipe_sram uut (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_drive (rd_drive),
        .sleeping (sleeping)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply(input logic c, input logic w, input logic o,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n = c; we_n = w; oe_n = o; addr = a; wr_data = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        apply(1'b1, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        // R1: during reset, outputs idle even with cs_n high
        check("R1 drive in reset", DW'(rd_drive), 9'h0);
        check("R1 sleep in reset", DW'(sleeping), 9'h0);
        check("R1 data in reset", rd_data, 9'h0);
        rst = 1'b0;
        apply(1'b0, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R1 drive after release", DW'(rd_drive), 9'h0);
        check("R1 sleep after release", DW'(sleeping), 9'h0);

        for (int j = 0; j < NV + 2; j++) begin
            if (j >= 1 && j - 1 < NV)
                check($sformatf("R6 sleep row %0d", j - 1), DW'(sleeping), DW'(TABLE[j-1].e_sleep));
            if (j >= 2) begin
                check($sformatf("R2/R7 drive row %0d", j - 2), DW'(rd_drive), DW'(TABLE[j-2].e_drive));
                check($sformatf("R10/R9 data row %0d", j - 2), rd_data, TABLE[j-2].e_data);
            end
            if (j < NV)
                apply(TABLE[j].cs_n, TABLE[j].we_n, TABLE[j].oe_n, TABLE[j].addr, TABLE[j].wdat);
            else
                apply(1'b0, 1'b1, 1'b1, '0, '0);
            @(negedge clk);
        end

        // R3: upper address bits fold onto the array (default depth 256)
        apply(1'b0, 1'b0, 1'b1, 18'h10009, 9'h0A7);
        @(negedge clk);
        apply(1'b0, 1'b1, 1'b0, 18'd9, '0);
        @(negedge clk);
        apply(1'b0, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R3 folded write read back", rd_data, 9'h0A7);
        check("R2 drive on folded read", DW'(rd_drive), 9'h1);

        // R1: mid-run reset clears output register and flags
        rst = 1'b1;
        apply(1'b1, 1'b1, 1'b0, '0, '0);
        @(negedge clk);
        check("R1 data cleared", rd_data, 9'h0);
        check("R1 drive cleared", DW'(rd_drive), 9'h0);
        check("R1 sleep held low", DW'(sleeping), 9'h0);
        rst = 1'b0;
        apply(1'b0, 1'b1, 1'b1, '0, '0);
        @(negedge clk);
        check("R1 sleep low after release", DW'(sleeping), 9'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule